// File: doc/BRIEF.md
# Bulk Payload Packetizer

This block sits between a payload source and a serial shifter and frames a bulk write that follows an accepted write command. A one-cycle start pulse gives it the total byte count and whether checksum trailers are wanted. It then pulls payload bytes from a valid/ready input stream and sends a framed byte stream out on a valid/ready output. The payload is cut into packets of at most `MAX_PKT` bytes, 8192 by default.

Every packet begins with a single marker byte that tells the receiver where the packet sits in the transfer. When trailers are enabled, each packet ends with two zero bytes where a checksum would go. The next marker follows the previous packet at once, with no gap and no response slot in between. Transfers that are too short for the bulk path are refused without sending anything. The end of a well-formed transfer is signalled by a single-cycle completion pulse.

Top module: `spi_blk_packetizer`

## Requirements
- R1: Each packet carries min(remaining, MAX_PKT) payload bytes, where remaining is the payload count not yet sent and MAX_PKT defaults to 8192. Payload bytes leave in the order they arrived.
- R2: A marker byte comes before each packet's payload. Its upper nibble is 0xF and its low two bits hold an order code: 1 for the first packet of a transfer that needs more than one packet, 2 for any packet that is neither first nor last, and 3 for the final packet.
- R3: The order code is 3 whenever the remaining count is at most MAX_PKT, including the first packet. A transfer of exactly MAX_PKT bytes is therefore a single packet marked 0xF3.
- R4: With trailers enabled, exactly two 0x00 bytes follow the payload of every packet. With trailers disabled, no bytes follow the payload.
- R5: The marker of the next packet follows the last byte of the previous packet directly, with no extra bytes between them.
- R6: A start with a total length of 4 or less is refused. `reject` goes high for one cycle after the start edge, `busy` stays low, `in_ready` stays low, and no output byte or `done` pulse is produced.
- R7: `done` is high for exactly one cycle, starting at the clock edge at which the final output byte is accepted. It occurs once per transfer.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. Output backpressure stalls input consumption with no byte lost or duplicated.
- R9: A start pulse that arrives while a transfer is in progress is ignored. The ongoing stream and its single `done` pulse are unchanged.
- R10: After reset, `out_valid`, `in_ready`, `busy`, `done` and `reject` are all low.
- R11: `busy` is high from the edge that accepts a valid start until the edge at which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_len | input | LEN_W | Total payload bytes, sampled with start |
| start_crc | input | 1 | Enables the two-byte trailer per packet, sampled with start |
| reject | output | 1 | One-cycle pulse: the start was refused as too short |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes the payload byte this cycle |
| out_valid | output | 1 | Framed byte available |
| out_data | output | 8 | Framed byte |
| out_ready | input | 1 | Shifter takes the framed byte this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the final framed byte |

## Verification
The bench targets the packet-size boundary: lengths of exactly MAX_PKT and MAX_PKT+1. A design with an off-by-one compare would either mark a single full packet 0xF1 or send an empty last packet. A three-packet transfer exercises the middle code 2, which a design that only tracks a first flag would never produce. The bench also applies random output backpressure with gaps in the input. A design that pulls input while its output register is full would drop or repeat payload bytes, and the content comparison would catch it. Short lengths (0 and 4) and a start arriving mid-transfer are applied as well. A design that let either through would emit stray bytes or raise a second `done`.

// File: rtl/spi_pkz_pkg.sv
package spi_pkz_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_TRL0,
    ST_TRL1,
    ST_DRAIN
  } pkz_state_t;

  localparam logic [7:0] HDR_TAG  = 8'hF0;
  localparam logic [7:0] TRL_BYTE = 8'h00;

  localparam logic [1:0] ORD_FIRST  = 2'd1;
  localparam logic [1:0] ORD_MIDDLE = 2'd2;
  localparam logic [1:0] ORD_FINAL  = 2'd3;

endpackage

// File: rtl/pkz_len_tracker.sv
module pkz_len_tracker #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             hdr_fire,
  input  logic             byte_fire,
  output logic [1:0]       order_code,
  output logic             pkt_last,
  output logic             xfer_last
);
  import spi_pkz_pkg::*;

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PKT);

  logic [LEN_W-1:0] rem_q;
  logic [PKT_W-1:0] pkt_left_q;
  logic             first_q;
  logic [PKT_W-1:0] pkt_size;

  // Size of the packet that the next marker opens
  assign pkt_size = (rem_q > MAX_L) ? PKT_W'(MAX_PKT) : rem_q[PKT_W-1:0];

  always_comb begin
    if (rem_q <= MAX_L)  order_code = ORD_FINAL;
    else if (first_q)    order_code = ORD_FIRST;
    else                 order_code = ORD_MIDDLE;
  end

  assign pkt_last  = (pkt_left_q == PKT_W'(1));
  assign xfer_last = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      pkt_left_q <= '0;
      first_q    <= 1'b0;
    end else if (load) begin
      rem_q      <= load_len;
      pkt_left_q <= '0;
      first_q    <= 1'b1;
    end else if (hdr_fire) begin
      pkt_left_q <= pkt_size;
      rem_q      <= rem_q - LEN_W'(pkt_size);
      first_q    <= 1'b0;
    end else if (byte_fire) begin
      pkt_left_q <= pkt_left_q - PKT_W'(1);
    end
  end

  // R1: a payload byte is only taken while the open packet still has room
  assert_pkt_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    byte_fire |-> (pkt_left_q != '0));

  // R1: every opened packet holds between 1 and MAX_PKT bytes
  assert_pkt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |=> ((pkt_left_q != '0) && (pkt_left_q <= PKT_W'(MAX_PKT))));

endmodule

// File: rtl/pkz_out_stage.sv
module pkz_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          can_load,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled byte stays put until it is taken
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: nothing is loaded on top of a byte that is not leaving
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> can_load);

endmodule

// File: rtl/spi_blk_packetizer.sv
module spi_blk_packetizer #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_crc,
  output logic             reject,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             done
);
  import spi_pkz_pkg::*;

  localparam int PKT_W = $clog2(MAX_PKT + 1);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  pkz_state_t state_q, state_d;
  logic       crc_q;
  logic       done_q;
  logic       reject_q;

  logic       start_ok, start_bad;
  logic       can_load, load;
  logic [7:0] load_data;
  logic       hdr_fire, byte_fire, trl_fire;
  logic [1:0] order_code;
  logic       pkt_last, xfer_last;

  assign start_ok  = start && (state_q == ST_IDLE) && (start_len >= MIN_L);
  assign start_bad = start && (state_q == ST_IDLE) && (start_len <  MIN_L);

  assign hdr_fire  = (state_q == ST_HDR) && can_load;
  assign in_ready  = (state_q == ST_DATA) && can_load;
  assign byte_fire = in_valid && in_ready;
  assign trl_fire  = ((state_q == ST_TRL0) || (state_q == ST_TRL1)) && can_load;
  assign load      = hdr_fire || byte_fire || trl_fire;

  always_comb begin
    if (hdr_fire)       load_data = HDR_TAG | {6'b0, order_code};
    else if (byte_fire) load_data = in_data;
    else                load_data = TRL_BYTE;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_HDR;
      ST_HDR:   if (can_load) state_d = ST_DATA;
      ST_DATA:  if (byte_fire && pkt_last) begin
                  if (crc_q)          state_d = ST_TRL0;
                  else if (xfer_last) state_d = ST_DRAIN;
                  else                state_d = ST_HDR;
                end
      ST_TRL0:  if (can_load) state_d = ST_TRL1;
      ST_TRL1:  if (can_load) state_d = xfer_last ? ST_DRAIN : ST_HDR;
      ST_DRAIN: if (out_valid && out_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      crc_q    <= 1'b0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= (state_q == ST_DRAIN) && out_valid && out_ready;
      reject_q <= start_bad;
      if (start_ok) crc_q <= start_crc;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign reject = reject_q;

  pkz_len_tracker #(
    .LEN_W  (LEN_W),
    .MAX_PKT(MAX_PKT),
    .PKT_W  (PKT_W)
  ) i_len (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .load_len  (start_len),
    .hdr_fire  (hdr_fire),
    .byte_fire (byte_fire),
    .order_code(order_code),
    .pkt_last  (pkt_last),
    .xfer_last (xfer_last)
  );

  pkz_out_stage #(
    .DW(8)
  ) i_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_data(load_data),
    .can_load (can_load),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ready(out_ready)
  );

  // R7: completion follows a byte actually taken by the shifter
  assert_done_after_byte_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(out_valid && out_ready));

  // R7: completion lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6: no payload is pulled outside a transfer
  assert_idle_no_input_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready);

  // R6: a refused start leaves the output silent
  assert_reject_silent_R6: assert property (@(posedge clk) disable iff (rst)
    reject_q |-> (!out_valid && !busy));

  // R11: the final byte is still held when draining begins
  assert_drain_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |-> out_valid);

endmodule

// File: tb/test_spi_blk_packetizer.sv
module test_spi_blk_packetizer;
  localparam int LEN_W   = 24;
  localparam int MAX_PKT = 8192;
  localparam int RX_SZ   = 32768;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [LEN_W-1:0] start_len = '0;
  logic             start_crc = 1'b0;
  logic             reject;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_ready;
  logic             out_valid;
  logic [7:0]       out_data;
  logic             out_ready = 1'b1;
  logic             busy;
  logic             done;

  int checks = 0;
  int fails  = 0;

  logic [7:0] rx [0:RX_SZ-1];
  int  rx_n = 0;
  int  done_n = 0;
  int  done_at = 0;
  int  stall_err = 0;
  bit  stall_mode = 1'b0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #2 clk = ~clk;

  spi_blk_packetizer #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .MIN_LEN(5)) i_spi_blk_packetizer (
    .clk(clk), .rst(rst), .start(start), .start_len(start_len), .start_crc(start_crc),
    .reject(reject), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13) + (i >> 8) + 5);
  endfunction

  // Output monitor: samples the handshake at the edge
  always @(posedge clk) begin
    if (!rst) begin
      if (prev_stall && (!out_valid || out_data != prev_data)) stall_err++;
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
      if (out_valid && out_ready) begin
        if (rx_n < RX_SZ) rx[rx_n] <= out_data;
        rx_n <= rx_n + 1;
      end
      if (done) begin
        done_n  <= done_n + 1;
        done_at <= rx_n;
      end
    end
  end

  always @(negedge clk) out_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input int len, input bit gaps, input int inj);
    for (int i = 0; i < len; i++) begin
      if (i == inj) begin
        in_valid = 1'b0;
        start = 1'b1; start_len = LEN_W'(50); start_crc = 1'b0;
        @(negedge clk);
        start = 1'b0;
      end
      if (gaps && (i % 3 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pat(i);
      @(posedge clk);
      while (!in_ready) @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Walks the expected framing and compares it with the captured stream
  task automatic verify(input int len, input bit crc);
    int idx = 0, rem = len, pi = 0, sz;
    bit first = 1'b1;
    bit hdr_ok = 1'b1, pay_ok = 1'b1, trl_ok = 1'b1;
    int hdr_a = 0, hdr_e = 0, pay_a = 0, pay_e = 0, trl_a = 0;
    logic [7:0] code;
    while (rem > 0) begin
      sz = (rem > MAX_PKT) ? MAX_PKT : rem;
      code = (rem <= MAX_PKT) ? 8'hF3 : (first ? 8'hF1 : 8'hF2);
      if (hdr_ok && rx[idx] !== code) begin hdr_ok = 0; hdr_a = rx[idx]; hdr_e = code; end
      idx++;
      for (int k = 0; k < sz; k++) begin
        if (pay_ok && rx[idx] !== pat(pi)) begin pay_ok = 0; pay_a = rx[idx]; pay_e = pat(pi); end
        idx++; pi++;
      end
      if (crc) for (int k = 0; k < 2; k++) begin
        if (trl_ok && rx[idx] !== 8'h00) begin trl_ok = 0; trl_a = rx[idx]; end
        idx++;
      end
      rem -= sz; first = 1'b0;
    end
    check(rx_n == idx, "R5 stream length", rx_n, idx);
    check(hdr_ok, "R2/R3 marker byte", hdr_a, hdr_e);
    check(pay_ok, "R1 payload bytes", pay_a, pay_e);
    check(trl_ok, "R4 trailer bytes", trl_a, 0);
    check(done_at == idx, "R7 done after last byte", done_at, idx);
    check(stall_err == 0, "R8 held under stall", stall_err, 0);
  endtask

  task automatic run_xfer(input int len, input bit crc, input bit stall,
                          input bit gaps, input int inj);
    int d0, t;
    @(negedge clk);
    rx_n = 0; stall_err = 0; stall_mode = stall;
    d0 = done_n;
    start = 1'b1; start_len = LEN_W'(len); start_crc = crc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    feed(len, gaps, inj);
    t = 0;
    while (done_n == d0 && t < 100000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(done_n == d0 + 1, "R7 single done", done_n - d0, 1);
    check(busy == 1'b0, "R11 idle after done", busy, 0);
    verify(len, crc);
    stall_mode = 1'b0;
  endtask

  task automatic test_reset();
    check(!out_valid && !in_ready && !busy && !done && !reject, "R10 reset state",
          {out_valid, in_ready, busy, done, reject}, 0);
  endtask

  task automatic test_reject(input int len);
    int d0 = done_n;
    bit rdy_seen = 1'b0;
    @(negedge clk);
    rx_n = 0;
    start = 1'b1; start_len = LEN_W'(len); start_crc = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(reject == 1'b1 && busy == 1'b0, "R6 reject pulse", {reject, busy}, 2);
    in_valid = 1'b1; in_data = 8'hAA;
    @(negedge clk);
    check(reject == 1'b0, "R6 reject one cycle", reject, 0);
    for (int i = 0; i < 6; i++) begin
      if (in_ready) rdy_seen = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!rdy_seen, "R6 no input taken", rdy_seen, 0);
    check(rx_n == 0 && done_n == d0, "R6 no output", rx_n, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_xfer(5, 1'b0, 1'b0, 1'b0, -1);            // R1 smallest accepted, single packet
    run_xfer(MAX_PKT, 1'b1, 1'b0, 1'b0, -1);      // R3 exactly one full packet, R4 trailer
    run_xfer(MAX_PKT + 1, 1'b1, 1'b0, 1'b0, -1);  // R2 first then final, R5 back to back
    run_xfer(20000, 1'b0, 1'b0, 1'b0, -1);        // R2 middle code, R4 no trailer
    run_xfer(9000, 1'b1, 1'b1, 1'b1, -1);         // R8 backpressure with input gaps
    run_xfer(300, 1'b1, 1'b0, 1'b0, 100);         // R9 start during transfer ignored
    test_reject(4);                               // R6 boundary
    test_reject(0);                               // R6 zero length
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule